// File: doc/BRIEF.md
# EEPROM Byte Access and Burst Loader

This controller lets a host move single bytes to and from a byte-addressed EEPROM. It can also run a burst load that copies records out of the EEPROM into on-chip memory. The host writes an address register and a data register, then sets a request bit in a two-bit control field. The hardware carries out the access over a request/acknowledge byte port and clears the request bit by itself when the access is done.

A burst is started with a single start bit. The controller then reads records from the EEPROM. Each record is a 16-bit address word, high byte first, followed by one data byte. For each record it writes the data byte to memory. The memory address joins a 9-bit base register, which supplies the upper bits, with the low 15 bits of the address word; bit 15 of the word is discarded. An address word of all ones ends the burst.

An internal pointer remembers where the EEPROM was last touched. The first burst after reset begins at EEPROM address 0. Any later burst picks up at the byte after the most recent single access or burst. The pointer wraps to 0 past the last address of a range whose size is set by a parameter.

Top module: `ee_loader`

## Requirements
- R1: After reset, busy, both control bits, the burst bit, the data and address registers, the EEPROM request and the memory write strobe are all 0.
- R2: Writing a control value with bit 1 set (bit 0 clear) reads the byte at the address register into the data register. Bit 1 reads back as 1 while the access runs and returns to 0 in the same cycle that busy drops, by which point the data register already holds the byte.
- R3: Writing a control value with bit 0 set writes the data register to the EEPROM at the address register, with the write strobe eeWe high. If both bits are written, only the write is done, and the control field reads 01 during the access. Bit 0 clears itself when the access finishes.
- R4: Writing 1 to bit 0 of the burst-start input starts a burst. The burst bit stays 1 until the terminating record is read, and then falls in the same cycle as busy.
- R5: The first burst after reset reads from EEPROM address 0. Every later burst reads from the address that follows the last byte touched by the previous single access or burst.
- R6: A burst reads records from consecutive EEPROM addresses, each record being address high byte, address low byte, then data byte.
- R7: For each record the controller pulses memWe for one cycle, with memAddr = {base[8:0], word[14:0]} and memWdata = the data byte. Bit 15 of the word is ignored.
- R8: A record whose address word is 0xFFFF ends the burst without a memory write. A word with a high byte of 0xFF and any other low byte is an ordinary record.
- R9: While busy, writes to the control, burst-start, address, data and base inputs are ignored, and busy stays 1 from the start of an operation to its end.
- R10: The address after EE_DEPTH-1 is 0, both for the continuation pointer and within a burst.
- R11: eeReq, once raised, is held with a stable eeAddr until eeAck is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Write strobe for the control field |
| ctlWrData | input | 2 | Bit 1 read request, bit 0 write request |
| burstWrEn | input | 1 | Write strobe for the burst-start bit |
| burstWrData | input | 1 | 1 starts a burst |
| addrWrEn | input | 1 | Write strobe for the address register |
| addrWrData | input | ADDR_W | New EEPROM byte address |
| dataWrEn | input | 1 | Write strobe for the data register |
| dataWrData | input | 8 | New data byte |
| baseWrEn | input | 1 | Write strobe for the base register |
| baseWrData | input | BASE_W | Upper memory address bits for bursts |
| ctlBits | output | 2 | Live control field (self-clearing) |
| burstBit | output | 1 | Live burst-start bit (self-clearing) |
| busy | output | 1 | An access or burst is running |
| addrReg | output | ADDR_W | Address register |
| dataReg | output | 8 | Data register |
| eeReq | output | 1 | EEPROM byte request |
| eeWe | output | 1 | Request is a write |
| eeAddr | output | ADDR_W | EEPROM byte address |
| eeWdata | output | 8 | Byte to write |
| eeAck | input | 1 | EEPROM completes the request this cycle |
| eeRdata | input | 8 | Byte read, valid with eeAck |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | MEM_AW | Memory write address |
| memWdata | output | 8 | Memory write data |

## Verification
The first burst after reset is compared with bursts that follow another burst, a single read, and a single read at the top address. These cases separate a start at address 0 from true continuation, and they also show the wrap. One record has a high byte of 0xFF and a low byte of 0x01, so a design that ends on the high byte alone loses that record. The bench answers requests with zero, one and two cycles of acknowledge latency, which separates a held request from one that moves too early. Control and address writes are made in the middle of a burst, and a request with both bits set shows that write wins over read.

// File: rtl/ee_loader_pkg.sv
package ee_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SGL, ST_HI, ST_LO, ST_DAT, ST_MEM
  } state_t;

  typedef enum logic [1:0] {
    CAP_NONE, CAP_HI, CAP_LO, CAP_DAT
  } cap_t;

  // strobes from the sequencer to the register datapath
  typedef struct packed {
    logic hostOpen;     // host register writes accepted
    logic sglStart;     // latch a single request
    logic bstStart;     // begin a burst
    logic sglDone;      // single access acknowledged
    logic bstStep;      // burst byte acknowledged, advance pointer
    cap_t capSel;       // which record byte to capture
    logic bstDone;      // terminating record seen
    logic useHostAddr;  // drive the host address to the EEPROM
    logic memWr;        // emit one memory write
  } strobe_t;

endpackage

// File: rtl/ee_loader_ctrl.sv
module ee_loader_ctrl
  import ee_loader_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrEn,
  input  logic [1:0] ctlWrData,
  input  logic       burstWrEn,
  input  logic       burstWrData,
  input  logic       eeAck,
  input  logic       endMark,
  output strobe_t    stb,
  output logic       busy,
  output logic       eeReq
);

  state_t st, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    stb    = '0;
    case (st)
      ST_IDLE: begin
        stb.hostOpen = 1'b1;
        if (ctlWrEn && (ctlWrData != 2'b00)) begin
          stb.sglStart = 1'b1;
          stNext       = ST_SGL;
        end else if (burstWrEn && burstWrData) begin
          stb.bstStart = 1'b1;
          stNext       = ST_HI;
        end
      end
      ST_SGL: begin
        stb.useHostAddr = 1'b1;
        if (eeAck) begin
          stb.sglDone = 1'b1;
          stNext      = ST_IDLE;
        end
      end
      ST_HI: if (eeAck) begin
        stb.bstStep = 1'b1;
        stb.capSel  = CAP_HI;
        stNext      = ST_LO;
      end
      ST_LO: if (eeAck) begin
        stb.bstStep = 1'b1;
        stb.capSel  = CAP_LO;
        if (endMark) begin
          stb.bstDone = 1'b1;
          stNext      = ST_IDLE;
        end else begin
          stNext      = ST_DAT;
        end
      end
      ST_DAT: if (eeAck) begin
        stb.bstStep = 1'b1;
        stb.capSel  = CAP_DAT;
        stNext      = ST_MEM;
      end
      ST_MEM: begin
        stb.memWr = 1'b1;
        stNext    = ST_HI;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  assign busy  = (st != ST_IDLE);
  assign eeReq = (st == ST_SGL) || (st == ST_HI) || (st == ST_LO) || (st == ST_DAT);

endmodule

// File: rtl/ee_loader_dp.sv
module ee_loader_dp
  import ee_loader_pkg::*;
#(
  parameter  int EE_DEPTH = 48,
  parameter  int BASE_W   = 9,
  parameter  int LOW_W    = 15,
  localparam int ADDR_W   = $clog2(EE_DEPTH),
  localparam int MEM_AW   = BASE_W + LOW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              wrPick,
  input  logic              addrWrEn,
  input  logic [ADDR_W-1:0] addrWrData,
  input  logic              dataWrEn,
  input  logic [7:0]        dataWrData,
  input  logic              baseWrEn,
  input  logic [BASE_W-1:0] baseWrData,
  input  logic [7:0]        eeRdata,
  output logic [1:0]        ctlBits,
  output logic              burstBit,
  output logic [ADDR_W-1:0] addrReg,
  output logic [7:0]        dataReg,
  output logic [ADDR_W-1:0] eeAddr,
  output logic              eeWe,
  output logic [7:0]        eeWdata,
  output logic              endMark,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [7:0]        memWdata
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(EE_DEPTH - 1);
  localparam int HI_KEEP = LOW_W - 8;

  logic [1:0]        ctlQ;
  logic              burstQ, touchedQ;
  logic [ADDR_W-1:0] addrQ, ptrQ;
  logic [7:0]        dataQ, hiQ, loQ, datQ;
  logic [BASE_W-1:0] baseQ;

  function automatic logic [ADDR_W-1:0] stepAddr(input logic [ADDR_W-1:0] a);
    return (a >= LAST_ADDR) ? '0 : a + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ     <= '0;
      burstQ   <= 1'b0;
      touchedQ <= 1'b0;
      addrQ    <= '0;
      ptrQ     <= '0;
      dataQ    <= '0;
      baseQ    <= '0;
      hiQ      <= '0;
      loQ      <= '0;
      datQ     <= '0;
    end else begin
      if (stb.hostOpen) begin
        if (addrWrEn) addrQ <= addrWrData;
        if (dataWrEn) dataQ <= dataWrData;
        if (baseWrEn) baseQ <= baseWrData;
      end
      if (stb.sglStart) ctlQ <= wrPick ? 2'b01 : 2'b10;
      if (stb.sglDone) begin
        ctlQ     <= '0;
        if (ctlQ[1]) dataQ <= eeRdata;
        ptrQ     <= stepAddr(addrQ);
        touchedQ <= 1'b1;
      end
      if (stb.bstStart) begin
        burstQ <= 1'b1;
        if (!touchedQ) ptrQ <= '0;
      end
      if (stb.bstStep) ptrQ <= stepAddr(ptrQ);
      case (stb.capSel)
        CAP_HI:  hiQ  <= eeRdata;
        CAP_LO:  loQ  <= eeRdata;
        CAP_DAT: datQ <= eeRdata;
        default: ;
      endcase
      if (stb.bstDone) begin
        burstQ   <= 1'b0;
        touchedQ <= 1'b1;
      end
    end
  end

  assign ctlBits  = ctlQ;
  assign burstBit = burstQ;
  assign addrReg  = addrQ;
  assign dataReg  = dataQ;
  assign eeAddr   = stb.useHostAddr ? addrQ : ptrQ;
  assign eeWe     = stb.useHostAddr & ctlQ[0];
  assign eeWdata  = dataQ;
  assign endMark  = (hiQ == 8'hFF) && (eeRdata == 8'hFF);
  assign memWe    = stb.memWr;
  assign memAddr  = {baseQ, hiQ[HI_KEEP-1:0], loQ};
  assign memWdata = datQ;

endmodule

// File: rtl/ee_loader.sv
module ee_loader
  import ee_loader_pkg::*;
#(
  parameter  int EE_DEPTH = 48,
  parameter  int BASE_W   = 9,
  parameter  int LOW_W    = 15,
  localparam int ADDR_W   = $clog2(EE_DEPTH),
  localparam int MEM_AW   = BASE_W + LOW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [1:0]        ctlWrData,
  input  logic              burstWrEn,
  input  logic              burstWrData,
  input  logic              addrWrEn,
  input  logic [ADDR_W-1:0] addrWrData,
  input  logic              dataWrEn,
  input  logic [7:0]        dataWrData,
  input  logic              baseWrEn,
  input  logic [BASE_W-1:0] baseWrData,
  output logic [1:0]        ctlBits,
  output logic              burstBit,
  output logic              busy,
  output logic [ADDR_W-1:0] addrReg,
  output logic [7:0]        dataReg,
  output logic              eeReq,
  output logic              eeWe,
  output logic [ADDR_W-1:0] eeAddr,
  output logic [7:0]        eeWdata,
  input  logic              eeAck,
  input  logic [7:0]        eeRdata,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [7:0]        memWdata
);

  strobe_t stb;
  logic    endMark;

  ee_loader_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .burstWrEn(burstWrEn), .burstWrData(burstWrData),
    .eeAck(eeAck), .endMark(endMark),
    .stb(stb), .busy(busy), .eeReq(eeReq)
  );

  ee_loader_dp #(.EE_DEPTH(EE_DEPTH), .BASE_W(BASE_W), .LOW_W(LOW_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrPick(ctlWrData[0]),
    .addrWrEn(addrWrEn), .addrWrData(addrWrData),
    .dataWrEn(dataWrEn), .dataWrData(dataWrData),
    .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .eeRdata(eeRdata),
    .ctlBits(ctlBits), .burstBit(burstBit), .addrReg(addrReg), .dataReg(dataReg),
    .eeAddr(eeAddr), .eeWe(eeWe), .eeWdata(eeWdata), .endMark(endMark),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

endmodule

// File: rtl/ee_loader_chk.sv
module ee_loader_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          ctlWrEn,
  input logic          addrWrEn,
  input logic          eeAck,
  input logic          busy,
  input logic [1:0]    ctlBits,
  input logic          burstBit,
  input logic [AW-1:0] addrReg,
  input logic          eeReq,
  input logic [AW-1:0] eeAddr,
  input logic          memWe
);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    eeReq && !eeAck |=> eeReq && $stable(eeAddr));

  // R9
  ctl_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && ctlWrEn && !eeAck |=> ctlBits == $past(ctlBits));

  // R9
  addr_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && addrWrEn |=> $stable(addrReg));

  // R4
  burst_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(burstBit) |-> !busy);

  // R7
  mem_in_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> burstBit && busy && !eeReq);

  // R3
  one_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctlBits));

endmodule

bind ee_loader ee_loader_chk #(.AW(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .addrWrEn(addrWrEn), .eeAck(eeAck),
  .busy(busy), .ctlBits(ctlBits), .burstBit(burstBit), .addrReg(addrReg),
  .eeReq(eeReq), .eeAddr(eeAddr), .memWe(memWe)
);

// File: tb/ee_loader_test.sv
module ee_loader_test;
  localparam int DEPTH = 48;
  localparam int AW    = 6;
  localparam int BW    = 9;
  localparam int MAW   = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic ctlWrEn = 0, burstWrEn = 0, burstWrData = 0, addrWrEn = 0, dataWrEn = 0, baseWrEn = 0;
  logic [1:0] ctlWrData = '0;
  logic [AW-1:0] addrWrData = '0;
  logic [7:0] dataWrData = '0;
  logic [BW-1:0] baseWrData = '0;
  logic [1:0] ctlBits;
  logic burstBit, busy, eeReq, eeWe, memWe;
  logic [AW-1:0] addrReg, eeAddr;
  logic [7:0] dataReg, eeWdata, memWdata;
  logic eeAck = 1'b0;
  logic [7:0] eeRdata = '0;
  logic [MAW-1:0] memAddr;

  ee_loader uut (.*);

  int total = 0, bad = 0;
  bit done = 0;

  task automatic check(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- EEPROM model ----------------
  logic [7:0] eeMem [DEPTH];
  int lat = 0;
  int waitCnt = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      eeAck <= 1'b0;
      waitCnt <= 0;
    end else if (eeReq && !eeAck) begin
      if (waitCnt >= lat) begin
        eeAck   <= 1'b1;
        eeRdata <= eeMem[eeAddr];
        if (eeWe) eeMem[eeAddr] <= eeWdata;
        waitCnt <= 0;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end else begin
      eeAck <= 1'b0;
    end
  end

  logic [31:0] memLog[$];
  always @(posedge clk) if (rstN && memWe) memLog.push_back({memAddr, memWdata});

  // ---------------- cycle reference model ----------------
  int ph = 0, mCtl = 0, mBurst = 0, mData = 0, mAddr = 0, mBase = 0, mPtr = 0;
  int mTouch = 0, mHi = 0, mLo = 0, mDat = 0;

  function automatic int nextA(int a);
    return (a >= DEPTH - 1) ? 0 : a + 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      ph = 0; mCtl = 0; mBurst = 0; mData = 0; mAddr = 0; mBase = 0;
      mPtr = 0; mTouch = 0; mHi = 0; mLo = 0; mDat = 0;
    end else begin
      case (ph)
        0: begin
          if (addrWrEn) mAddr = int'(addrWrData);
          if (dataWrEn) mData = int'(dataWrData);
          if (baseWrEn) mBase = int'(baseWrData);
          if (ctlWrEn && ctlWrData != 0) begin
            ph = 1; mCtl = ctlWrData[0] ? 1 : 2;
          end else if (burstWrEn && burstWrData) begin
            ph = 2; mBurst = 1;
            if (mTouch == 0) mPtr = 0;
          end
        end
        1: if (eeAck) begin
          if (mCtl == 2) mData = int'(eeRdata);
          mPtr = nextA(mAddr); mTouch = 1; mCtl = 0; ph = 0;
        end
        2: if (eeAck) begin mHi = int'(eeRdata); mPtr = nextA(mPtr); ph = 3; end
        3: if (eeAck) begin
          mLo = int'(eeRdata); mPtr = nextA(mPtr);
          if (mHi == 255 && mLo == 255) begin ph = 0; mBurst = 0; mTouch = 1; end
          else ph = 4;
        end
        4: if (eeAck) begin mDat = int'(eeRdata); mPtr = nextA(mPtr); ph = 5; end
        default: ph = 2;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check("R9",  "cycle busy",    busy,    ph != 0);
      check("R3",  "cycle ctlBits", ctlBits, mCtl);
      check("R4",  "cycle burstBit", burstBit, mBurst);
      check("R2",  "cycle dataReg", dataReg, mData);
      check("R9",  "cycle addrReg", addrReg, mAddr);
      check("R11", "cycle eeReq",   eeReq,   ph >= 1 && ph <= 4);
      if (eeReq) begin
        check("R5", "cycle eeAddr", eeAddr, (ph == 1) ? mAddr : mPtr);
        check("R3", "cycle eeWe",   eeWe,   ph == 1 && mCtl == 1);
      end
      check("R7", "cycle memWe", memWe, ph == 5);
      if (memWe) begin
        check("R7", "cycle memAddr", memAddr, (mBase << 15) | ((mHi & 127) << 8) | mLo);
        check("R7", "cycle memWdata", memWdata, mDat);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int which, input int val);
    @(negedge clk);
    case (which)
      0: begin ctlWrEn = 1; ctlWrData = 2'(val); end
      1: begin burstWrEn = 1; burstWrData = 1'(val); end
      2: begin addrWrEn = 1; addrWrData = AW'(val); end
      3: begin dataWrEn = 1; dataWrData = 8'(val); end
      default: begin baseWrEn = 1; baseWrData = BW'(val); end
    endcase
    @(negedge clk);
    ctlWrEn = 0; burstWrEn = 0; addrWrEn = 0; dataWrEn = 0; baseWrEn = 0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) eeMem[i] = 8'((i * 13 + 1) & 127);
    eeMem[0] = 8'h81; eeMem[1] = 8'h23; eeMem[2] = 8'h5A;
    eeMem[3] = 8'h00; eeMem[4] = 8'h10; eeMem[5] = 8'hC3;
    eeMem[6] = 8'hFF; eeMem[7] = 8'h01; eeMem[8] = 8'h77;
    eeMem[9] = 8'hFF; eeMem[10] = 8'hFF;
    eeMem[11] = 8'h00; eeMem[12] = 8'h44; eeMem[13] = 8'h99;
    eeMem[14] = 8'hFF; eeMem[15] = 8'hFF;

    repeat (3) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R1", "reset busy", busy, 0);
    check("R1", "reset ctlBits", ctlBits, 0);
    check("R1", "reset burstBit", burstBit, 0);
    check("R1", "reset dataReg", dataReg, 0);
    check("R1", "reset addrReg", addrReg, 0);
    check("R1", "reset eeReq", eeReq, 0);
    check("R1", "reset memWe", memWe, 0);
    rstN = 1'b1;

    // first burst after reset, slow acknowledge, with ignored writes
    wr(4, 'h1A3);
    lat = 2;
    wr(1, 1);
    check("R4", "burst bit during burst", burstBit, 1);
    check("R9", "busy during burst", busy, 1);
    repeat (2) @(negedge clk);
    wr(0, 2);
    check("R9", "ctl write ignored while busy", ctlBits, 0);
    wr(2, 7);
    wr(1, 1);
    waitIdle();
    check("R4", "burst bit cleared", burstBit, 0);
    check("R9", "address write ignored while busy", addrReg, 0);
    check("R8", "records in first burst", memLog.size(), 3);
    if (memLog.size() >= 3) begin
      check("R5", "first record from address 0", memLog[0], 32'hD181235A);
      check("R6", "second record", memLog[1], 32'hD18010C3);
      check("R8", "high byte FF is not an end", memLog[2], 32'hD1FF0177);
    end

    // burst continues after burst
    wr(4, 1);
    lat = 0;
    wr(1, 1);
    waitIdle();
    check("R5", "records after continuation", memLog.size(), 4);
    if (memLog.size() >= 4) check("R5", "continuation record", memLog[3], 32'h00804499);

    // single read, then burst continues after it
    wr(2, 5);
    wr(0, 2);
    check("R2", "read bit while busy", ctlBits, 2);
    waitIdle();
    check("R2", "read bit self-clears", ctlBits, 0);
    check("R2", "read data", dataReg, 8'hC3);
    wr(1, 1);
    waitIdle();
    check("R5", "records after single", memLog.size(), 5);
    if (memLog.size() >= 5) check("R7", "bit 15 dropped", memLog[4], 32'h00FF0177);

    // write with both bits set, then read it back
    wr(3, 'hA5);
    wr(2, 20);
    lat = 1;
    wr(0, 3);
    check("R3", "write wins over read", ctlBits, 1);
    check("R3", "write strobe", eeWe, 1);
    check("R3", "write data", eeWdata, 8'hA5);
    waitIdle();
    check("R3", "write bit self-clears", ctlBits, 0);
    check("R3", "eeprom holds byte", eeMem[20], 8'hA5);
    wr(3, 0);
    wr(0, 2);
    waitIdle();
    check("R3", "read back written byte", dataReg, 8'hA5);

    // read at the top address, burst wraps to 0
    wr(2, 47);
    wr(0, 2);
    waitIdle();
    check("R2", "read top address", dataReg, 8'h64);
    wr(4, 'h0F0);
    wr(1, 1);
    waitIdle();
    check("R10", "records after wrap", memLog.size(), 8);
    if (memLog.size() >= 8) begin
      check("R10", "wrapped record 0", memLog[5], 32'h7801235A);
      check("R10", "wrapped record 1", memLog[6], 32'h780010C3);
      check("R10", "wrapped record 2", memLog[7], 32'h787F0177);
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R4 watchdog act=busy exp=idle");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule